// File: doc/BRIEF.md
# Transfer Submission Queue with Tag Completion Tracking

This block is the register-facing front end of one DMA channel. Software writes the destination and source addresses, the two step sizes, the inner and outer counts and a small flag field into staging registers. It then writes the go register. The staged values are captured into a short request queue, together with a 5-bit tag. Before submitting, software can read the tag that the request will receive from a dedicated register. Tags are issued in increasing order and wrap from 31 back to 0.

A data-mover stub takes the oldest queued request whenever it is idle. It presents the request on the mover outputs with a one-cycle start pulse and stays busy for a fixed number of cycles. Leaving the queue raises a start event and finishing raises an end event. Both events are latched into a write-one-to-clear pending register. A mask register decides which pending events reach the single interrupt line. Finished requests set their tag's bit in a 32-bit write-one-to-clear completion register. While the queue holds its full number of waiting requests, the go register reads back 1 and further submissions are dropped. Software waits for a start event before it tries again.

Top module: `txq_front`

## Requirements
- R1: After reset, the interrupt mask, pending, completion and next-tag registers all read 0, the go register reads 0 and `irq` is low.
- R2: The next-tag register (offset 0x03) returns the tag that the next accepted submission receives. Each accepted submission advances it by one, and it wraps from 31 to 0.
- R3: A write of 1 in bit 0 to the go register (offset 0x02) is accepted only while the queue is not full. While QDEPTH requests wait, the go register reads 1, and a write to it consumes no tag and starts no transfer.
- R4: On `mv_start`, the mover outputs carry the values staged at submission time: the inner and outer counts (offsets 0x08 and 0x09, each written as count minus one), the destination (0x0A), the source (0x0B), the destination and source steps (0x0C, 0x0D), the flags (0x0E) and the tag. `mv_total` equals (inner+1)*(outer+1).
- R5: Pending bit 0 (start) is set on the clock edge where a request leaves the queue, the same edge that raises `mv_start`. Pending bit 1 (end) is set LATENCY edges later, when that request finishes.
- R6: When the request with tag n finishes, bit n of the completion register (offset 0x04) is set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R7: `irq` is high exactly when some pending bit (offset 0x01) is set and its mask bit (offset 0x00, 1 = suppress) is clear. Writing 1 to a pending bit clears it.
- R8: Offsets with no register, including 0x10 and 0x3F, read 0 and ignore writes. Read-only registers ignore writes.
- R9: Requests run one at a time in submission order. A request's end event always follows its own start event.
- R10: While one request is being moved, QDEPTH (at least 2) further requests can be accepted before the queue reports full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word offset |
| rd_data | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt, any unmasked pending event |
| mv_start | output | 1 | One-cycle pulse: a request has been handed to the mover |
| mv_busy | output | 1 | Mover is working on a request |
| mv_tag | output | 5 | Tag of the current request |
| mv_dst | output | 32 | Destination address |
| mv_src | output | 32 | Source address |
| mv_dst_step | output | 16 | Destination step |
| mv_src_step | output | 16 | Source step |
| mv_xcnt | output | 8 | Inner count minus one |
| mv_ycnt | output | 8 | Outer count minus one |
| mv_flags | output | 4 | Request flags |
| mv_total | output | 17 | Element total (xcnt+1)*(ycnt+1) |

## Verification
The bench runs more than a full lap of tags, so the wrap from 31 to 0 is exercised. A tag counter that saturated or skipped would show up as a wrong next-tag read or a wrong completion bit. It fills the queue behind a running request and then issues one more go write. A design that accepted it, or that consumed a tag for it, would run a fourth request or report a shifted next tag. The bench samples the start and end events on the exact cycles they must appear and checks every mask combination on the interrupt line. This catches an off-by-one in the latency, a mis-wired pending bit, and inverted mask polarity. Sweeping the counts through several values checks the count-minus-one convention in the computed total.

// File: rtl/txq_pkg.sv
// Package: shared widths, register offsets and the queued request record.
package txq_pkg;
    localparam int DATA_W = 32;
    localparam int REG_AW = 6;
    localparam int TAG_W  = 5;
    localparam int LEN_W  = 8;
    localparam int STEP_W = 16;
    localparam int FLAG_W = 4;
    localparam int TOT_W  = 2 * LEN_W + 1;
    localparam int NTAGS  = 1 << TAG_W;

    localparam logic [REG_AW-1:0] OFF_IRQ_MASK = 6'h00;
    localparam logic [REG_AW-1:0] OFF_IRQ_PEND = 6'h01;
    localparam logic [REG_AW-1:0] OFF_GO       = 6'h02;
    localparam logic [REG_AW-1:0] OFF_NEXT_TAG = 6'h03;
    localparam logic [REG_AW-1:0] OFF_DONE     = 6'h04;
    localparam logic [REG_AW-1:0] OFF_XCNT     = 6'h08;
    localparam logic [REG_AW-1:0] OFF_YCNT     = 6'h09;
    localparam logic [REG_AW-1:0] OFF_DST      = 6'h0A;
    localparam logic [REG_AW-1:0] OFF_SRC      = 6'h0B;
    localparam logic [REG_AW-1:0] OFF_DSTEP    = 6'h0C;
    localparam logic [REG_AW-1:0] OFF_SSTEP    = 6'h0D;
    localparam logic [REG_AW-1:0] OFF_FLAGS    = 6'h0E;

    localparam int EV_SOT = 0;
    localparam int EV_EOT = 1;
    localparam int EV_N   = 2;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] src;
        logic [STEP_W-1:0] dstep;
        logic [STEP_W-1:0] sstep;
        logic [LEN_W-1:0]  xcnt;
        logic [LEN_W-1:0]  ycnt;
        logic [FLAG_W-1:0] flags;
    } txq_req_t;
endpackage

// File: rtl/txq_fifo.sv
// Request queue: first-in first-out store of DEPTH request records.
// Assumes the caller never pushes when full nor pops when empty.
module txq_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  txq_req_t push_req,
    input  logic     pop,
    output txq_req_t head,
    output logic     empty,
    output logic     full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    txq_req_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];

    // Storage write: record lands at the write pointer on push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_req;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            if (push && !pop)      count <= count + CNT_W'(1);
            else if (pop && !push) count <= count - CNT_W'(1);
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> (count < CNT_W'(DEPTH))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> (count != '0)); // R9
endmodule

// File: rtl/txq_mover_stub.sv
// Data-mover stand-in: takes the queue head when idle, holds it for
// LATENCY cycles, then reports it finished. Assumes LATENCY >= 1.
module txq_mover_stub
    import txq_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_empty,
    input  txq_req_t         q_head,
    output logic             pop,
    output logic             start_pulse,
    output logic             busy,
    output logic             sot_evt,
    output logic             eot_evt,
    output txq_req_t         cur,
    output logic [TOT_W-1:0] total
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0]     cnt;
    logic [LEN_W:0]       xn, yn;
    logic [2*LEN_W+1:0]   prod;

    assign pop     = !busy && !q_empty;
    assign sot_evt = pop;
    assign eot_evt = busy && (cnt == '0);

    // Element total from the minus-one counts.
    always_comb begin
        xn    = {1'b0, cur.xcnt} + (LEN_W+1)'(1);
        yn    = {1'b0, cur.ycnt} + (LEN_W+1)'(1);
        prod  = {{(LEN_W+1){1'b0}}, xn} * {{(LEN_W+1){1'b0}}, yn};
        total = prod[TOT_W-1:0];
    end

    // Busy window: load on pop, count down, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            cnt         <= '0;
            start_pulse <= 1'b0;
            cur         <= '0;
        end else begin
            start_pulse <= pop;
            if (pop) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(LATENCY - 1);
                cur  <= q_head;
            end else if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - CNT_W'(1);
            end
        end
    end

    AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cnt <= CNT_W'(LATENCY - 1))); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |-> busy); // R9
endmodule

// File: rtl/txq_irq_ctl.sv
// Interrupt control: latches start/end events into write-one-to-clear
// pending bits and drives the line from unmasked pending bits.
module txq_irq_ctl
    import txq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sot_evt,
    input  logic            eot_evt,
    input  logic            mask_we,
    input  logic            pend_we,
    input  logic [EV_N-1:0] wdata,
    output logic [EV_N-1:0] mask,
    output logic [EV_N-1:0] pend,
    output logic            irq
);
    logic [EV_N-1:0] ev_set;
    logic [EV_N-1:0] ev_clr;

    always_comb begin
        ev_set         = '0;
        ev_set[EV_SOT] = sot_evt;
        ev_set[EV_EOT] = eot_evt;
        ev_clr         = pend_we ? wdata : '0;
    end

    // Mask register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wdata;
    end

    // Pending register: new events win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~ev_clr) | ev_set;
    end

    assign irq = |(pend & ~mask);

    AST_SOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n) sot_evt |=> pend[EV_SOT]); // R5
    AST_EOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n) eot_evt |=> pend[EV_EOT]); // R5
endmodule

// File: rtl/txq_front.sv
// Channel front end: staging registers, tag issue, request queue,
// mover stub, completion bitmask and interrupt control.
// Assumes one register access per cycle per port; reads have no side effects.
module txq_front
    import txq_pkg::*;
#(
    parameter int QDEPTH  = 2,
    parameter int LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              mv_start,
    output logic              mv_busy,
    output logic [TAG_W-1:0]  mv_tag,
    output logic [DATA_W-1:0] mv_dst,
    output logic [DATA_W-1:0] mv_src,
    output logic [STEP_W-1:0] mv_dst_step,
    output logic [STEP_W-1:0] mv_src_step,
    output logic [LEN_W-1:0]  mv_xcnt,
    output logic [LEN_W-1:0]  mv_ycnt,
    output logic [FLAG_W-1:0] mv_flags,
    output logic [TOT_W-1:0]  mv_total
);
    // Staging registers
    logic [DATA_W-1:0] st_dst, st_src;
    logic [STEP_W-1:0] st_dstep, st_sstep;
    logic [LEN_W-1:0]  st_xcnt, st_ycnt;
    logic [FLAG_W-1:0] st_flags;

    logic [TAG_W-1:0]  next_tag;
    logic [NTAGS-1:0]  done_map;

    logic     go_req, push, pop, q_empty, q_full;
    logic     sot_evt, eot_evt;
    txq_req_t push_req, q_head, cur;
    logic [EV_N-1:0] irq_mask, irq_pend;

    assign go_req = wr_en && (wr_addr == OFF_GO) && wr_data[0];
    assign push   = go_req && !q_full;

    always_comb begin
        push_req.tag   = next_tag;
        push_req.dst   = st_dst;
        push_req.src   = st_src;
        push_req.dstep = st_dstep;
        push_req.sstep = st_sstep;
        push_req.xcnt  = st_xcnt;
        push_req.ycnt  = st_ycnt;
        push_req.flags = st_flags;
    end

    // Staging register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_dst <= '0; st_src <= '0; st_dstep <= '0; st_sstep <= '0;
            st_xcnt <= '0; st_ycnt <= '0; st_flags <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                OFF_DST:   st_dst   <= wr_data;
                OFF_SRC:   st_src   <= wr_data;
                OFF_DSTEP: st_dstep <= wr_data[STEP_W-1:0];
                OFF_SSTEP: st_sstep <= wr_data[STEP_W-1:0];
                OFF_XCNT:  st_xcnt  <= wr_data[LEN_W-1:0];
                OFF_YCNT:  st_ycnt  <= wr_data[LEN_W-1:0];
                OFF_FLAGS: st_flags <= wr_data[FLAG_W-1:0];
                default: ;
            endcase
        end
    end

    // Tag issue: advance on every accepted submission, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)    next_tag <= '0;
        else if (push) next_tag <= next_tag + TAG_W'(1);
    end

    txq_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_req(push_req),
        .pop(pop), .head(q_head), .empty(q_empty), .full(q_full)
    );

    txq_mover_stub #(.LATENCY(LATENCY)) u_mover (
        .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head(q_head),
        .pop(pop), .start_pulse(mv_start), .busy(mv_busy),
        .sot_evt(sot_evt), .eot_evt(eot_evt), .cur(cur), .total(mv_total)
    );

    txq_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .sot_evt(sot_evt), .eot_evt(eot_evt),
        .mask_we(wr_en && (wr_addr == OFF_IRQ_MASK)),
        .pend_we(wr_en && (wr_addr == OFF_IRQ_PEND)),
        .wdata(wr_data[EV_N-1:0]), .mask(irq_mask), .pend(irq_pend), .irq(irq)
    );

    // Completion bitmask: finished tag sets its bit, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_map <= '0;
        end else begin
            for (int i = 0; i < NTAGS; i++) begin
                if (eot_evt && (cur.tag == TAG_W'(i)))
                    done_map[i] <= 1'b1;
                else if (wr_en && (wr_addr == OFF_DONE) && wr_data[i])
                    done_map[i] <= 1'b0;
            end
        end
    end

    assign mv_tag      = cur.tag;
    assign mv_dst      = cur.dst;
    assign mv_src      = cur.src;
    assign mv_dst_step = cur.dstep;
    assign mv_src_step = cur.sstep;
    assign mv_xcnt     = cur.xcnt;
    assign mv_ycnt     = cur.ycnt;
    assign mv_flags    = cur.flags;

    // Read mux: unmapped offsets return zero.
    always_comb begin
        case (rd_addr)
            OFF_IRQ_MASK: rd_data = DATA_W'(irq_mask);
            OFF_IRQ_PEND: rd_data = DATA_W'(irq_pend);
            OFF_GO:       rd_data = DATA_W'(q_full);
            OFF_NEXT_TAG: rd_data = DATA_W'(next_tag);
            OFF_DONE:     rd_data = DATA_W'(done_map);
            OFF_XCNT:     rd_data = DATA_W'(st_xcnt);
            OFF_YCNT:     rd_data = DATA_W'(st_ycnt);
            OFF_DST:      rd_data = st_dst;
            OFF_SRC:      rd_data = st_src;
            OFF_DSTEP:    rd_data = DATA_W'(st_dstep);
            OFF_SSTEP:    rd_data = DATA_W'(st_sstep);
            OFF_FLAGS:    rd_data = DATA_W'(st_flags);
            default:      rd_data = '0;
        endcase
    end

    AST_TAG_STEP:   assert property (@(posedge clk) disable iff (!rst_n) push |=> (next_tag == $past(next_tag) + TAG_W'(1))); // R2
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (go_req && q_full) |=> (next_tag == $past(next_tag))); // R3
endmodule

// File: tb/txq_front_bench.sv
`timescale 1ns/1ps
module txq_front_bench;
    localparam int QD  = 2;
    localparam int LAT = 8;

    localparam logic [5:0] A_MASK = 6'h00, A_PEND = 6'h01, A_GO = 6'h02, A_TAG = 6'h03,
                           A_DONE = 6'h04, A_X = 6'h08, A_Y = 6'h09, A_DST = 6'h0A,
                           A_SRC = 6'h0B, A_DSTEP = 6'h0C, A_SSTEP = 6'h0D, A_FLAGS = 6'h0E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq, mv_start, mv_busy;
    logic [4:0]  mv_tag;
    logic [31:0] mv_dst, mv_src;
    logic [15:0] mv_dst_step, mv_src_step;
    logic [7:0]  mv_xcnt, mv_ycnt;
    logic [3:0]  mv_flags;
    logic [16:0] mv_total;

    int tests = 0, fails = 0;
    bit finished = 1'b0;
    bit rec_on = 1'b0;
    int n_log = 0;
    logic [4:0] tag_log [8];

    always #2.5 clk = ~clk;

    txq_front #(.QDEPTH(QD), .LATENCY(LAT)) u_txq_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .mv_start(mv_start),
        .mv_busy(mv_busy), .mv_tag(mv_tag), .mv_dst(mv_dst), .mv_src(mv_src),
        .mv_dst_step(mv_dst_step), .mv_src_step(mv_src_step), .mv_xcnt(mv_xcnt),
        .mv_ycnt(mv_ycnt), .mv_flags(mv_flags), .mv_total(mv_total)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    // Records start order during the queue-fill test.
    always @(negedge clk) begin
        if (rec_on && mv_start && n_log < 8) begin
            tag_log[n_log] = mv_tag;
            n_log++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [4:0]  base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_rd(A_MASK, 0, "R1 mask");
        chk_rd(A_PEND, 0, "R1 pending");
        chk_rd(A_DONE, 0, "R1 done");
        chk_rd(A_TAG, 0, "R1 next tag");
        chk_rd(A_GO, 0, "R1 go");
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R8: unmapped and read-only offsets
        wr(6'h10, 32'hFFFF_FFFF);
        chk_rd(6'h10, 0, "R8 offset 0x10");
        wr(6'h3F, 32'hA5A5_A5A5);
        chk_rd(6'h3F, 0, "R8 offset 0x3F");
        wr(A_TAG, 32'h1F);
        chk_rd(A_TAG, 0, "R8 read-only tag");
        chk_rd(A_MASK, 0, "R8 mask untouched");

        // R4: staging readback
        wr(A_X, 3); wr(A_Y, 1); wr(A_DST, 32'h1000_0040); wr(A_SRC, 32'h2000_0080);
        wr(A_DSTEP, 16'h0100); wr(A_SSTEP, 16'h0200); wr(A_FLAGS, 4'h5);
        chk_rd(A_X, 3, "R4 xcnt readback");
        chk_rd(A_DST, 32'h1000_0040, "R4 dst readback");

        // R5/R6/R7/R9: single transfer with exact timing
        wr(A_GO, 1);
        @(negedge clk);
        chk(mv_start == 1'b1, "R5 start pulse", mv_start, 1);
        chk(mv_tag == 0, "R4 tag", mv_tag, 0);
        chk(mv_dst == 32'h1000_0040 && mv_src == 32'h2000_0080, "R4 addresses", mv_dst, 32'h1000_0040);
        chk(mv_dst_step == 16'h0100 && mv_src_step == 16'h0200, "R4 steps", mv_src_step, 16'h0200);
        chk(mv_flags == 4'h5, "R4 flags", mv_flags, 5);
        chk(mv_total == 8, "R4 total", mv_total, 8);
        chk_rd(A_PEND, 1, "R5 start pending only");
        chk(irq == 1'b1, "R7 irq on start", irq, 1);
        chk_rd(A_DONE, 0, "R9 not done at start");
        repeat (LAT - 1) @(negedge clk);
        chk_rd(A_DONE, 0, "R5 done not early");
        @(negedge clk);
        chk_rd(A_DONE, 1, "R6 done bit 0");
        chk_rd(A_PEND, 3, "R5 end pending");
        wr(A_MASK, 1);
        chk(irq == 1'b1, "R7 end unmasked", irq, 1);
        wr(A_MASK, 2);
        chk(irq == 1'b1, "R7 start unmasked", irq, 1);
        wr(A_MASK, 3);
        chk(irq == 1'b0, "R7 all masked", irq, 0);
        wr(A_PEND, 1);
        chk_rd(A_PEND, 2, "R7 clear start only");
        wr(A_PEND, 2);
        wr(A_MASK, 0);
        chk(irq == 1'b0, "R7 nothing pending", irq, 0);
        wr(A_DONE, 0);
        chk_rd(A_DONE, 1, "R6 zero write keeps");
        wr(A_DONE, 1);
        chk_rd(A_DONE, 0, "R6 w1c");

        // R2/R4/R6: sweep past the tag wrap
        for (int i = 1; i <= 40; i++) begin
            logic [4:0] et;
            et = 5'(i % 32);
            wr(A_X, i % 7); wr(A_Y, i % 4); wr(A_DST, i << 8); wr(A_SRC, ~(i << 4));
            wr(A_FLAGS, i % 16);
            chk_rd(A_TAG, 32'(et), "R2 next tag");
            wr(A_GO, 1);
            for (int k = 0; k < 20 && !mv_start; k++) @(negedge clk);
            chk(mv_tag == et, "R2 issued tag", mv_tag, et);
            chk(mv_total == 17'(((i % 7) + 1) * ((i % 4) + 1)), "R4 total sweep",
                mv_total, ((i % 7) + 1) * ((i % 4) + 1));
            chk(mv_dst == 32'(i << 8) && mv_flags == 4'(i % 16), "R4 fields sweep", mv_dst, i << 8);
            repeat (LAT) @(negedge clk);
            chk_rd(A_DONE, 32'h1 << et, "R6 done bit sweep");
            wr(A_DONE, 32'h1 << et);
            wr(A_PEND, 3);
        end
        chk_rd(A_TAG, 9, "R2 wrapped tag");

        // R3/R9/R10: fill the queue behind a running request
        rd(A_TAG, v);
        base = v[4:0];
        rec_on = 1'b1;
        wr(A_GO, 1);
        wr(A_GO, 1);
        wr(A_GO, 1);
        chk_rd(A_GO, 1, "R10 full after depth");
        chk_rd(A_TAG, 32'(5'(base + 3)), "R10 three accepted");
        wr(A_GO, 1);
        chk_rd(A_TAG, 32'(5'(base + 3)), "R3 full drop keeps tag");
        for (int k = 0; k < 200; k++) begin
            rd(A_DONE, v);
            if (v == ((32'h1 << base) | (32'h1 << 5'(base + 1)) | (32'h1 << 5'(base + 2)))) break;
            @(negedge clk);
        end
        chk(v == ((32'h1 << base) | (32'h1 << 5'(base + 1)) | (32'h1 << 5'(base + 2))),
            "R9 all three done", v, 0);
        repeat (2 * LAT) @(negedge clk);
        chk(n_log == 3, "R3 dropped request not run", n_log, 3);
        chk(tag_log[0] == base && tag_log[1] == 5'(base + 1) && tag_log[2] == 5'(base + 2),
            "R9 submission order", tag_log[1], 5'(base + 1));
        chk_rd(A_GO, 0, "R3 not full after drain");
        rec_on = 1'b0;

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule